// File: doc/BRIEF.md
# Floating-Point Register Stack File

This block holds the eight 80-bit extended-precision operands of a floating-point unit. It presents them as a circular stack rather than as fixed addresses. A 3-bit top pointer names the physical entry that is currently the stack top. Every access uses a relative index: slot ST(i) is physical entry (top + i) mod 8. Each entry also carries a 2-bit content tag. The tag classifies the stored value, so the execution logic can tell empty slots from live ones without decoding the 80 bits again.

Each cycle, one operation code selects one of the following:
- a push, which loads a new value into a freshly opened top slot;
- a pop, which discards the top;
- a write of a result into ST(i);
- a write of a result into ST(i) followed by a pop in the same step.

Two independent read ports return any two relative slots combinationally. A plain store is a read of ST(0) with no operation, and store-and-pop is a read of ST(0) during a pop. A two-operand arithmetic step has this form: it reads ST(0) and ST(1), writes the result into ST(1) and pops, so the result becomes the new ST(0).

The block checks every operation for stack faults before it commits. A fault leaves the stack untouched and shows up as a one-cycle overflow or underflow flag.

Top module: `fpstk_file`

## Requirements
- R1: After synchronous reset the top pointer is 0, both fault flags are low, and every entry reads back with tag 2'b11 (empty).
- R2: Read port A (and likewise B) returns, in the same cycle and without a clock edge, the data and tag of physical entry (top + idx) mod 8.
- R3: Operation code 3'd1 (push) decrements the top pointer modulo 8, so 0 becomes 7. It stores the write data in the new ST(0) and tags it by its content.
- R4: Operation code 3'd2 (pop) marks the current ST(0) empty and increments the top pointer modulo 8. The value that a read port shows at ST(0) during that cycle is the value that was popped.
- R5: A written or pushed value is tagged from its exponent field (bits 78:64) and its significand field (bits 63:0):
  - 2'b01 (zero) when both fields are zero;
  - 2'b10 (special) when the exponent is all ones, or when the exponent is zero and the significand is nonzero;
  - 2'b00 (valid) otherwise.
- R6: Operation code 3'd3 writes the write data into ST(wr_idx) and leaves the top pointer unchanged.
- R7: Operation code 3'd4 writes ST(wr_idx) and then pops. With wr_idx = 1 the written value becomes the new ST(0). With wr_idx = 0 the written entry ends up empty.
- R8: A push whose target entry (old ST(7)) is not empty is an overflow. The stack is left unchanged, and the overflow flag is high in the following cycle.
- R9: An underflow is any of the following:
  - a pop with an empty ST(0);
  - a write-and-pop with an empty ST(0);
  - a read on an enabled read port of an empty entry.
  On an underflow the stack is left unchanged, and the underflow flag is high in the following cycle.
- R10: Each fault flag reflects only the operation of the previous cycle. Operation codes 3'd0 and 3'd5 to 3'd7 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Operation code: 0 none, 1 push, 2 pop, 3 write, 4 write then pop |
| wr_idx_i | input | 3 | Relative slot written by codes 3 and 4 |
| wr_data_i | input | 80 | Value pushed or written |
| rd_a_en_i | input | 1 | Port A read is live (checked for underflow) |
| rd_a_idx_i | input | 3 | Relative slot read on port A |
| rd_a_data_o | output | 80 | Port A data |
| rd_a_tag_o | output | 2 | Port A tag |
| rd_b_en_i | input | 1 | Port B read is live (checked for underflow) |
| rd_b_idx_i | input | 3 | Relative slot read on port B |
| rd_b_data_o | output | 80 | Port B data |
| rd_b_tag_o | output | 2 | Port B tag |
| top_o | output | 3 | Current top-of-stack physical entry |
| ovf_o | output | 1 | Stack overflow in the previous cycle |
| unf_o | output | 1 | Stack underflow in the previous cycle |

## Verification
The assertions check the following pointer and tag rules on every cycle:
- a committed push moves the pointer down by one, and a committed pop or write-and-pop moves it up by one;
- a fault freezes the pointer, and any other operation leaves it unchanged;
- an entry cleared by a pop is empty on the next cycle, even when it was written in the same step;
- a written entry carries the tag computed for it;
- a flag never appears without a matching cause.

Other behaviours can only be shown by the bench's scenarios:
- the relative-to-physical mapping as the pointer wraps;
- the returned data, with its content classification;
- overflow on a full stack and underflow on an empty one;
- the ordering of a write-and-pop on slot 0 versus slot 1.

// File: rtl/fpstk_pkg.sv
package fpstk_pkg;

    localparam int unsigned FP_W  = 80;
    localparam int unsigned EXP_W = 15;
    localparam int unsigned SIG_W = 64;

    typedef enum logic [1:0] {
        TAG_VALID   = 2'b00,
        TAG_ZERO    = 2'b01,
        TAG_SPECIAL = 2'b10,
        TAG_EMPTY   = 2'b11
    } tag_e;

    typedef enum logic [2:0] {
        OP_NOP   = 3'd0,
        OP_PUSH  = 3'd1,
        OP_POP   = 3'd2,
        OP_WRITE = 3'd3,
        OP_WRPOP = 3'd4
    } op_e;

    typedef struct packed {
        logic             sign;
        logic [EXP_W-1:0] expo;
        logic [SIG_W-1:0] sig;
    } fpx_t;

    // Content class of an extended-precision value
    function automatic tag_e classify(input fpx_t v);
        tag_e t;
        if (v.expo == '0 && v.sig == '0)
            t = TAG_ZERO;
        else if (v.expo == '1 || v.expo == '0)
            t = TAG_SPECIAL;
        else
            t = TAG_VALID;
        return t;
    endfunction

endpackage

// File: rtl/fpstk_tagger.sv
module fpstk_tagger
    import fpstk_pkg::*;
(
    input  fpx_t val_i,
    output tag_e tag_o
);

    always_comb begin
        tag_o = classify(val_i);
    end

endmodule

// File: rtl/fpstk_ctl.sv
module fpstk_ctl
    import fpstk_pkg::*;
#(
    parameter  int unsigned DEPTH = 8,
    localparam int unsigned PTR_W = $clog2(DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [2:0]            op_i,
    input  logic [PTR_W-1:0]      wr_idx_i,
    input  logic                  rd_a_en_i,
    input  logic [PTR_W-1:0]      rd_a_idx_i,
    input  logic                  rd_b_en_i,
    input  logic [PTR_W-1:0]      rd_b_idx_i,
    input  logic [DEPTH-1:0][1:0] tags_i,
    output logic [PTR_W-1:0]      top_o,
    output logic                  ovf_o,
    output logic                  unf_o,
    output logic                  wr_en_o,
    output logic [PTR_W-1:0]      wr_phys_o,
    output logic                  clr_en_o,
    output logic [PTR_W-1:0]      clr_phys_o,
    output logic [PTR_W-1:0]      rd_a_phys_o,
    output logic [PTR_W-1:0]      rd_b_phys_o
);

    op_e              op;
    logic [PTR_W-1:0] top_q, top_d, push_slot;
    logic             ovf_now, unf_now, fault;
    logic             ovf_q, unf_q;
    logic             pops, writes;

    assign op          = op_e'(op_i);
    assign push_slot   = top_q - PTR_W'(1);
    assign rd_a_phys_o = top_q + rd_a_idx_i;
    assign rd_b_phys_o = top_q + rd_b_idx_i;

    assign pops   = (op == OP_POP) || (op == OP_WRPOP);
    assign writes = (op == OP_PUSH) || (op == OP_WRITE) || (op == OP_WRPOP);

    always_comb begin
        ovf_now = (op == OP_PUSH) && (tags_i[push_slot] != TAG_EMPTY);
        unf_now = (pops && (tags_i[top_q] == TAG_EMPTY))
               || (rd_a_en_i && (tags_i[rd_a_phys_o] == TAG_EMPTY))
               || (rd_b_en_i && (tags_i[rd_b_phys_o] == TAG_EMPTY));
        fault   = ovf_now || unf_now;
    end

    assign wr_en_o    = writes && !fault;
    assign wr_phys_o  = (op == OP_PUSH) ? push_slot : (top_q + wr_idx_i);
    assign clr_en_o   = pops && !fault;
    assign clr_phys_o = top_q;

    always_comb begin
        top_d = top_q;
        if (!fault) begin
            case (op)
                OP_PUSH:         top_d = push_slot;
                OP_POP, OP_WRPOP: top_d = top_q + PTR_W'(1);
                default:         top_d = top_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            top_q <= '0;
            ovf_q <= 1'b0;
            unf_q <= 1'b0;
        end else begin
            top_q <= top_d;
            ovf_q <= ovf_now;
            unf_q <= unf_now;
        end
    end

    assign top_o = top_q;
    assign ovf_o = ovf_q;
    assign unf_o = unf_q;

    AST_PUSH_DECREMENTS: assert property (@(posedge clk) disable iff (rst)
        (op == OP_PUSH && !fault) |=> (top_q == PTR_W'($past(top_q) - PTR_W'(1)))); // R3

    AST_POP_INCREMENTS: assert property (@(posedge clk) disable iff (rst)
        (pops && !fault) |=> (top_q == PTR_W'($past(top_q) + PTR_W'(1)))); // R4

    AST_FAULT_FREEZES_TOP: assert property (@(posedge clk) disable iff (rst)
        fault |=> $stable(top_q)); // R8

    AST_IDLE_KEEPS_TOP: assert property (@(posedge clk) disable iff (rst)
        (op != OP_PUSH && !pops) |=> $stable(top_q)); // R10

    AST_OVF_NEEDS_PUSH: assert property (@(posedge clk) disable iff (rst)
        (op != OP_PUSH) |=> !ovf_q); // R10

    AST_UNF_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        (!pops && !rd_a_en_i && !rd_b_en_i) |=> !unf_q); // R9

endmodule

// File: rtl/fpstk_regs.sv
module fpstk_regs
    import fpstk_pkg::*;
#(
    parameter  int unsigned DEPTH = 8,
    localparam int unsigned PTR_W = $clog2(DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en_i,
    input  logic [PTR_W-1:0]      wr_phys_i,
    input  fpx_t                  wr_data_i,
    input  tag_e                  wr_tag_i,
    input  logic                  clr_en_i,
    input  logic [PTR_W-1:0]      clr_phys_i,
    input  logic [PTR_W-1:0]      rd_a_phys_i,
    input  logic [PTR_W-1:0]      rd_b_phys_i,
    output fpx_t                  rd_a_data_o,
    output logic [1:0]            rd_a_tag_o,
    output fpx_t                  rd_b_data_o,
    output logic [1:0]            rd_b_tag_o,
    output logic [DEPTH-1:0][1:0] tags_o
);

    logic [DEPTH-1:0][1:0]    tag_vec;
    logic [DEPTH-1:0][FP_W-1:0] data_vec;

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        logic [1:0] tag_q;
        fpx_t       data_q;
        logic       hit_wr, hit_clr;

        assign hit_wr  = wr_en_i  && (wr_phys_i  == PTR_W'(g));
        assign hit_clr = clr_en_i && (clr_phys_i == PTR_W'(g));

        // Clear wins: a pop follows the write within the same step
        always_ff @(posedge clk) begin
            if (rst)
                tag_q <= TAG_EMPTY;
            else if (hit_clr)
                tag_q <= TAG_EMPTY;
            else if (hit_wr)
                tag_q <= wr_tag_i;
        end

        always_ff @(posedge clk) begin
            if (rst)
                data_q <= '0;
            else if (hit_wr)
                data_q <= wr_data_i;
        end

        assign tag_vec[g]  = tag_q;
        assign data_vec[g] = data_q;
    end

    assign rd_a_data_o = data_vec[rd_a_phys_i];
    assign rd_a_tag_o  = tag_vec[rd_a_phys_i];
    assign rd_b_data_o = data_vec[rd_b_phys_i];
    assign rd_b_tag_o  = tag_vec[rd_b_phys_i];
    assign tags_o      = tag_vec;

    AST_POP_CLEARS: assert property (@(posedge clk) disable iff (rst)
        clr_en_i |=> (tag_vec[$past(clr_phys_i)] == TAG_EMPTY)); // R7

    AST_WRITE_TAGGED: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && !(clr_en_i && clr_phys_i == wr_phys_i))
        |=> (tag_vec[$past(wr_phys_i)] == $past(wr_tag_i))); // R5

endmodule

// File: rtl/fpstk_file.sv
module fpstk_file
    import fpstk_pkg::*;
#(
    parameter  int unsigned DEPTH = 8,
    localparam int unsigned PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       op_i,
    input  logic [PTR_W-1:0] wr_idx_i,
    input  logic [FP_W-1:0]  wr_data_i,
    input  logic             rd_a_en_i,
    input  logic [PTR_W-1:0] rd_a_idx_i,
    output logic [FP_W-1:0]  rd_a_data_o,
    output logic [1:0]       rd_a_tag_o,
    input  logic             rd_b_en_i,
    input  logic [PTR_W-1:0] rd_b_idx_i,
    output logic [FP_W-1:0]  rd_b_data_o,
    output logic [1:0]       rd_b_tag_o,
    output logic [PTR_W-1:0] top_o,
    output logic             ovf_o,
    output logic             unf_o
);

    logic [DEPTH-1:0][1:0] tags;
    logic                  wr_en, clr_en;
    logic [PTR_W-1:0]      wr_phys, clr_phys, rd_a_phys, rd_b_phys;
    tag_e                  wr_tag;
    fpx_t                  wr_val, a_val, b_val;

    assign wr_val = fpx_t'(wr_data_i);

    fpstk_tagger u_tagger (
        .val_i (wr_val),
        .tag_o (wr_tag)
    );

    fpstk_ctl #(.DEPTH(DEPTH)) u_ctl (
        .clk         (clk),
        .rst         (rst),
        .op_i        (op_i),
        .wr_idx_i    (wr_idx_i),
        .rd_a_en_i   (rd_a_en_i),
        .rd_a_idx_i  (rd_a_idx_i),
        .rd_b_en_i   (rd_b_en_i),
        .rd_b_idx_i  (rd_b_idx_i),
        .tags_i      (tags),
        .top_o       (top_o),
        .ovf_o       (ovf_o),
        .unf_o       (unf_o),
        .wr_en_o     (wr_en),
        .wr_phys_o   (wr_phys),
        .clr_en_o    (clr_en),
        .clr_phys_o  (clr_phys),
        .rd_a_phys_o (rd_a_phys),
        .rd_b_phys_o (rd_b_phys)
    );

    fpstk_regs #(.DEPTH(DEPTH)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .wr_en_i     (wr_en),
        .wr_phys_i   (wr_phys),
        .wr_data_i   (wr_val),
        .wr_tag_i    (wr_tag),
        .clr_en_i    (clr_en),
        .clr_phys_i  (clr_phys),
        .rd_a_phys_i (rd_a_phys),
        .rd_b_phys_i (rd_b_phys),
        .rd_a_data_o (a_val),
        .rd_a_tag_o  (rd_a_tag_o),
        .rd_b_data_o (b_val),
        .rd_b_tag_o  (rd_b_tag_o),
        .tags_o      (tags)
    );

    assign rd_a_data_o = a_val;
    assign rd_b_data_o = b_val;

endmodule

// File: tb/fpstk_file_bench.sv
module fpstk_file_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  op_i;
    logic [2:0]  wr_idx_i;
    logic [79:0] wr_data_i;
    logic        rd_a_en_i, rd_b_en_i;
    logic [2:0]  rd_a_idx_i, rd_b_idx_i;
    logic [79:0] rd_a_data_o, rd_b_data_o;
    logic [1:0]  rd_a_tag_o, rd_b_tag_o;
    logic [2:0]  top_o;
    logic        ovf_o, unf_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [79:0] m_data [8];
    logic [1:0]  m_tag  [8];
    logic [2:0]  m_top;

    always #(CLK_PERIOD/2) clk = ~clk;

    fpstk_file u_fpstk_file (
        .clk(clk), .rst(rst), .op_i(op_i), .wr_idx_i(wr_idx_i), .wr_data_i(wr_data_i),
        .rd_a_en_i(rd_a_en_i), .rd_a_idx_i(rd_a_idx_i), .rd_a_data_o(rd_a_data_o),
        .rd_a_tag_o(rd_a_tag_o), .rd_b_en_i(rd_b_en_i), .rd_b_idx_i(rd_b_idx_i),
        .rd_b_data_o(rd_b_data_o), .rd_b_tag_o(rd_b_tag_o), .top_o(top_o),
        .ovf_o(ovf_o), .unf_o(unf_o)
    );

    function automatic logic [1:0] cls(input logic [79:0] d);
        if (d[78:64] == 15'h0 && d[63:0] == 64'h0) return 2'b01;
        if (d[78:64] == 15'h7fff || d[78:64] == 15'h0) return 2'b10;
        return 2'b00;
    endfunction

    function automatic logic [79:0] rnd_val();
        logic [79:0] v;
        int k = int'($urandom % 4);
        v[79]    = 1'($urandom);
        v[63:32] = $urandom;
        v[31:0]  = $urandom;
        case (k)
            0, 1: begin v[78:64] = 15'(1 + ($urandom % 32'h7ffe)); v[63] = 1'b1; end
            2:    v[78:0] = '0;
            default: begin
                if ($urandom % 2 == 0) v[78:64] = 15'h7fff;
                else begin v[78:64] = 15'h0; v[0] = 1'b1; end
            end
        endcase
        return v;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [79:0] act, input logic [79:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // Observe one relative slot without changing state
    task automatic peek(input logic [2:0] idx, input logic [79:0] ed, input logic [1:0] et,
                        input bit cmp_data, input string req);
        @(negedge clk);
        op_i = 3'd0; rd_a_en_i = 1'b0; rd_b_en_i = 1'b0; rd_a_idx_i = idx;
        #1;
        chk(rd_a_tag_o == et, req, 80'(rd_a_tag_o), 80'(et));
        if (cmp_data) chk(rd_a_data_o == ed, req, rd_a_data_o, ed);
    endtask

    task automatic step(input logic [2:0] op, input logic [2:0] widx, input logic [79:0] wd,
                        input logic aen, input logic [2:0] aidx,
                        input logic ben, input logic [2:0] bidx);
        logic [2:0] pa, pb, ps, pw;
        logic ov, un;
        string req;
        @(negedge clk);
        op_i = op; wr_idx_i = widx; wr_data_i = wd;
        rd_a_en_i = aen; rd_a_idx_i = aidx; rd_b_en_i = ben; rd_b_idx_i = bidx;
        #1;
        pa = m_top + aidx;
        pb = m_top + bidx;
        ps = m_top - 3'd1;
        chk(rd_a_tag_o == m_tag[pa], "R2 port A tag", 80'(rd_a_tag_o), 80'(m_tag[pa]));
        if (m_tag[pa] != 2'b11) chk(rd_a_data_o == m_data[pa], "R2 port A data", rd_a_data_o, m_data[pa]);
        chk(rd_b_tag_o == m_tag[pb], "R2 port B tag", 80'(rd_b_tag_o), 80'(m_tag[pb]));
        if (m_tag[pb] != 2'b11) chk(rd_b_data_o == m_data[pb], "R2 port B data", rd_b_data_o, m_data[pb]);
        ov = (op == 3'd1) && (m_tag[ps] != 2'b11);
        un = ((op == 3'd2 || op == 3'd4) && m_tag[m_top] == 2'b11)
          || (aen && m_tag[pa] == 2'b11) || (ben && m_tag[pb] == 2'b11);
        if (!(ov || un)) begin
            pw = m_top + widx;
            case (op)
                3'd1: begin m_top = ps; m_data[ps] = wd; m_tag[ps] = cls(wd); end
                3'd2: begin m_tag[m_top] = 2'b11; m_top = m_top + 3'd1; end
                3'd3: begin m_data[pw] = wd; m_tag[pw] = cls(wd); end
                3'd4: begin
                    m_data[pw] = wd; m_tag[pw] = cls(wd);
                    m_tag[m_top] = 2'b11; m_top = m_top + 3'd1;
                end
                default: ;
            endcase
        end
        case (op)
            3'd1: req = "R3 top after push";
            3'd2: req = "R4 top after pop";
            3'd3: req = "R6 top after write";
            3'd4: req = "R7 top after write-pop";
            default: req = "R10 top after idle";
        endcase
        @(posedge clk);
        #1;
        chk(top_o == m_top, req, 80'(top_o), 80'(m_top));
        chk(ovf_o == ov, "R8 overflow flag", 80'(ovf_o), 80'(ov));
        chk(unf_o == un, "R9 underflow flag", 80'(unf_o), 80'(un));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [79:0] v0, v1, v2;
        void'($urandom(32'd20240611));
        rst = 1'b1; op_i = 3'd0; wr_idx_i = 3'd0; wr_data_i = '0;
        rd_a_en_i = 1'b0; rd_b_en_i = 1'b0; rd_a_idx_i = 3'd0; rd_b_idx_i = 3'd0;
        for (int i = 0; i < 8; i++) begin m_tag[i] = 2'b11; m_data[i] = '0; end
        m_top = 3'd0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state
        chk(top_o == 3'd0, "R1 reset top", 80'(top_o), 80'(0));
        chk(!ovf_o && !unf_o, "R1 reset flags", 80'({ovf_o, unf_o}), 80'(0));
        for (int i = 0; i < 8; i++) peek(3'(i), '0, 2'b11, 1'b0, "R1 reset tag empty");

        // R3 / R5: push wraps 0 -> 7, one value of each class
        v0 = {1'b0, 15'h3fff, 1'b1, 63'h1234};
        v1 = {1'b1, 15'h0, 64'h0};
        v2 = {1'b0, 15'h7fff, 64'hc000_0000_0000_0000};
        step(3'd1, 3'd0, v0, 1'b0, 3'd0, 1'b0, 3'd0);
        chk(top_o == 3'd7, "R3 push wraps to 7", 80'(top_o), 80'(7));
        peek(3'd0, v0, 2'b00, 1'b1, "R5 valid tag");
        step(3'd1, 3'd0, v1, 1'b0, 3'd0, 1'b0, 3'd0);
        peek(3'd0, v1, 2'b01, 1'b1, "R5 zero tag");
        step(3'd1, 3'd0, v2, 1'b0, 3'd0, 1'b0, 3'd0);
        peek(3'd0, v2, 2'b10, 1'b1, "R5 special tag");
        step(3'd1, 3'd0, {1'b0, 15'h0, 64'h5}, 1'b0, 3'd0, 1'b0, 3'd0);
        peek(3'd0, {1'b0, 15'h0, 64'h5}, 2'b10, 1'b1, "R5 denormal tag");
        // R2: relative mapping ST(3) is the first pushed value
        peek(3'd3, v0, 2'b00, 1'b1, "R2 ST(3) mapping");

        // R8: fill the stack then push once more
        for (int i = 0; i < 4; i++) step(3'd1, 3'd0, rnd_val(), 1'b0, 3'd0, 1'b0, 3'd0);
        step(3'd1, 3'd0, rnd_val(), 1'b0, 3'd0, 1'b0, 3'd0);
        chk(ovf_o == 1'b1, "R8 overflow on full", 80'(ovf_o), 80'(1));
        peek(3'd7, v0, 2'b00, 1'b1, "R8 stack unchanged");
        step(3'd0, 3'd0, '0, 1'b0, 3'd0, 1'b0, 3'd0);
        chk(ovf_o == 1'b0, "R10 flag clears", 80'(ovf_o), 80'(0));

        // R6: write ST(2)
        step(3'd3, 3'd2, v2, 1'b0, 3'd0, 1'b0, 3'd0);
        peek(3'd2, v2, 2'b10, 1'b1, "R6 write ST(2)");

        // R7: arithmetic-style write ST(1) and pop
        step(3'd4, 3'd1, v1, 1'b1, 3'd0, 1'b1, 3'd1);
        peek(3'd0, v1, 2'b01, 1'b1, "R7 result is new ST(0)");
        // R7: write ST(0) and pop leaves that entry empty
        step(3'd4, 3'd0, v0, 1'b0, 3'd0, 1'b0, 3'd0);
        peek(3'd7, '0, 2'b11, 1'b0, "R7 write-pop slot 0 empty");

        // R10: undefined codes change nothing
        v2 = m_data[m_top];
        step(3'd6, 3'd0, rnd_val(), 1'b0, 3'd0, 1'b0, 3'd0);
        peek(3'd0, v2, m_tag[m_top], 1'b1, "R10 undefined op ignored");

        // R4: store-and-pop down to empty, then underflow
        while (m_tag[m_top] != 2'b11) begin
            v2 = m_data[m_top];
            @(negedge clk); rd_a_idx_i = 3'd0; op_i = 3'd0; #1;
            chk(rd_a_data_o == v2, "R4 value read before pop", rd_a_data_o, v2);
            step(3'd2, 3'd0, '0, 1'b1, 3'd0, 1'b0, 3'd0);
        end
        step(3'd2, 3'd0, '0, 1'b0, 3'd0, 1'b0, 3'd0);
        chk(unf_o == 1'b1, "R9 underflow on empty pop", 80'(unf_o), 80'(1));
        step(3'd0, 3'd0, '0, 1'b1, 3'd5, 1'b0, 3'd0);
        chk(unf_o == 1'b1, "R9 underflow on empty read", 80'(unf_o), 80'(1));

        // Random mix against the bench model
        for (int n = 0; n < 4000; n++) begin
            int r = int'($urandom % 10);
            logic [2:0] op;
            case (r)
                0, 1, 2, 3: op = 3'd1;
                4, 5:       op = 3'd2;
                6:          op = 3'd3;
                7:          op = 3'd4;
                8:          op = 3'd0;
                default:    op = 3'(5 + ($urandom % 3));
            endcase
            step(op, 3'($urandom), rnd_val(), 1'($urandom % 3 == 0), 3'($urandom),
                 1'($urandom % 3 == 0), 3'($urandom));
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule